// File: doc/BRIEF.md
# Multi-Category Wavefront Issue Scheduler

This block is the instruction issue arbiter of a compute unit built from several SIMDs, each owning a fixed number of wavefront slots. Every slot reports three things: whether it holds a live wave, whether that wave's next instruction is ready, and a 3-bit category code for that instruction. Each downstream execution category also has a busy input that holds back issue into it.

On every clock cycle one SIMD is the candidate. The candidate SIMD advances in round-robin order. From the waves of the candidate SIMD, the block grants at most one instruction per category, so up to five instructions can issue in one cycle. Within a category, the pick is made by a rotating pointer kept for each SIMD and category pair.

The grant vector has one bit per slot and is combinational from the current inputs and the internal state. The execution pipelines consume the grant in the same cycle. A separate count output reports how many grants are active.

Top module: `wave_issue_sched`

## Requirements
- R1: `sel_simd` is 0 in the first cycle after reset. It then steps by one each cycle, wrapping from NUM_SIMD-1 to 0. It advances whether or not anything issues.
- R2: Only slots of the SIMD shown on `sel_simd` can be granted. Slot w belongs to SIMD w / SLOTS, at position w % SLOTS.
- R3: A slot can be granted only if all of these hold: its valid bit is high, its ready bit is high, its category code is below 5, and the busy bit of that category is low.
- R4: In any cycle each category receives at most one grant. Since a slot carries a single category, a wave receives at most one grant.
- R5: If the selected SIMD has at least one slot that is eligible under R3 for a category, exactly one slot of that category is granted.
- R6: Within a SIMD and category, the search begins at a pointer that resets to 0. It picks the first eligible slot at or after the pointer, wrapping around. After a grant, the pointer moves to the slot after the granted one.
- R7: `issue_cnt` equals the number of set bits in `grant` and never exceeds 5.
- R8: The category codes are: 0 for vector ALU (matrix multiply-add included), 1 for vector memory, 2 for scalar ALU and scalar memory, 3 for scratchpad, and 4 for branch. Five waves with five distinct codes in the selected SIMD all issue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | NUM_SIMD*SLOTS | Slot holds a live wave |
| slot_ready | input | NUM_SIMD*SLOTS | Next instruction of the slot is ready |
| slot_cat | input | NUM_SIMD*SLOTS*3 | Category code per slot, 3 bits each, slot w at bits [3w+2:3w] |
| cat_busy | input | 5 | Downstream busy per category code |
| grant | output | NUM_SIMD*SLOTS | Issue grant per slot |
| sel_simd | output | $clog2(NUM_SIMD) | SIMD considered this cycle |
| issue_cnt | output | 3 | Number of grants this cycle |

## Verification
The bench builds the block with its defaults: four SIMDs of eight slots each, five categories. With these values the full five-wide issue from one SIMD can be exercised, and so can the wrap of the SIMD counter from 3 back to 0. A vector-memory conflict placed in SIMD 0 is revisited on three successive turns, which carries its pointer from 0 past slot 7 and back around. SIMD 3 combines not-ready slots, a busy category, a slot that is ready but not valid, and an out-of-range code. Its next turn then shows the held-back slot issuing once the category is released.

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
  parameter int NUM_SIMD = 4,
  parameter int SLOTS    = 8,
  parameter int NUM_CAT  = 5,
  parameter int CAT_W    = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_SIMD*SLOTS-1:0]             slot_valid,
  input  logic [NUM_SIMD*SLOTS-1:0]             slot_ready,
  input  logic [NUM_SIMD*SLOTS*CAT_W-1:0]       slot_cat,
  input  logic [NUM_CAT-1:0]                    cat_busy,
  output logic [NUM_SIMD*SLOTS-1:0]             grant,
  output logic [$clog2(NUM_SIMD)-1:0]           sel_simd,
  output logic [$clog2(NUM_CAT+1)-1:0]          issue_cnt
);
  localparam int SIMD_W = $clog2(NUM_SIMD);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(NUM_CAT+1);

  logic [SIMD_W-1:0] sel_q;
  logic [SLOT_W-1:0] ptr_q [NUM_SIMD][NUM_CAT];
  logic [SLOTS-1:0]  elig  [NUM_CAT];
  logic [SLOT_W-1:0] win   [NUM_CAT];
  logic [NUM_CAT-1:0] hit;

  assign sel_simd = sel_q;

  always_comb begin
    for (int c = 0; c < NUM_CAT; c++) begin
      for (int s = 0; s < SLOTS; s++) begin
        int w;
        w = int'(sel_q) * SLOTS + s;
        elig[c][s] = slot_valid[w] && slot_ready[w] && !cat_busy[c] &&
                     (int'(slot_cat[w*CAT_W +: CAT_W]) == c);
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CAT; c++) begin
      hit[c] = 1'b0;
      win[c] = '0;
      for (int i = 0; i < SLOTS; i++) begin
        int j;
        j = (int'(ptr_q[int'(sel_q)][c]) + i) % SLOTS;
        if (!hit[c] && elig[c][j]) begin
          hit[c] = 1'b1;
          win[c] = SLOT_W'(j);
        end
      end
    end
  end

  always_comb begin
    grant = '0;
    for (int c = 0; c < NUM_CAT; c++)
      if (hit[c]) grant[int'(sel_q) * SLOTS + int'(win[c])] = 1'b1;
  end

  always_comb begin
    issue_cnt = '0;
    for (int c = 0; c < NUM_CAT; c++) issue_cnt = issue_cnt + CNT_W'(hit[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int m = 0; m < NUM_SIMD; m++)
        for (int c = 0; c < NUM_CAT; c++) ptr_q[m][c] <= '0;
    end else begin
      sel_q <= (int'(sel_q) == NUM_SIMD-1) ? '0 : sel_q + 1'b1;
      for (int c = 0; c < NUM_CAT; c++)
        if (hit[c])
          ptr_q[int'(sel_q)][c] <= (int'(win[c]) == SLOTS-1) ? '0 : win[c] + 1'b1;
    end
  end
endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
  parameter int NUM_SIMD = 4,
  parameter int SLOTS    = 8,
  parameter int NUM_CAT  = 5,
  parameter int CAT_W    = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_SIMD*SLOTS-1:0]         slot_valid,
  input logic [NUM_SIMD*SLOTS-1:0]         slot_ready,
  input logic [NUM_SIMD*SLOTS*CAT_W-1:0]   slot_cat,
  input logic [NUM_CAT-1:0]                cat_busy,
  input logic [NUM_SIMD*SLOTS-1:0]         grant,
  input logic [$clog2(NUM_SIMD)-1:0]       sel_simd,
  input logic [$clog2(NUM_CAT+1)-1:0]      issue_cnt
);
  localparam int NW = NUM_SIMD * SLOTS;

  logic [NW-1:0] simd_mask;
  logic [NW-1:0] cat_mask [NUM_CAT];
  logic [NW-1:0] slot_ok;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      int c;
      c = int'(slot_cat[w*CAT_W +: CAT_W]);
      simd_mask[w] = (w / SLOTS) == int'(sel_simd);
      slot_ok[w] = slot_valid[w] && slot_ready[w] && (c < NUM_CAT) &&
                   !(((cat_busy >> c) & 1) != 0);
      for (int k = 0; k < NUM_CAT; k++) cat_mask[k][w] = (c == k);
    end
  end

  // R1
  sel_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(sel_simd) == ((int'($past(sel_simd)) == NUM_SIMD-1) ? 0 : int'($past(sel_simd)) + 1));

  // R2
  grant_in_simd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~simd_mask) == '0);

  // R3
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~slot_ok) == '0);

  // R7
  issue_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(issue_cnt) == $countones(grant)) && (issue_cnt <= 5));

  generate
    for (genvar k = 0; k < NUM_CAT; k++) begin : g_cat
      // R4
      one_per_cat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant & cat_mask[k]));
      // R5
      work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(slot_ok & simd_mask & cat_mask[k])) |-> (|(grant & cat_mask[k])));
    end
  endgenerate
endmodule

bind wave_issue_sched wave_issue_sched_chk #(
  .NUM_SIMD(NUM_SIMD), .SLOTS(SLOTS), .NUM_CAT(NUM_CAT), .CAT_W(CAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
  .slot_cat(slot_cat), .cat_busy(cat_busy), .grant(grant),
  .sel_simd(sel_simd), .issue_cnt(issue_cnt)
);

// File: tb/wave_issue_sched_tb.sv
module wave_issue_sched_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] valid = '0;
  logic [31:0] ready = '0;
  logic [95:0] cat = '0;
  logic [4:0]  busy = '0;
  logic [31:0] grant;
  logic [1:0]  sel_simd;
  logic [2:0]  issue_cnt;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_issue_sched u_dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(valid), .slot_ready(ready),
    .slot_cat(cat), .cat_busy(busy), .grant(grant),
    .sel_simd(sel_simd), .issue_cnt(issue_cnt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    valid = '0; ready = '0; cat = '0; busy = '0;
  endtask

  task automatic set_slot(int simd, int slot, int c, bit v, bit r);
    int w;
    w = simd * 8 + slot;
    valid[w] = v;
    ready[w] = r;
    cat[w*3 +: 3] = 3'(c);
  endtask

  task automatic wait_sel(int k);
    @(negedge clk);
    while (int'(sel_simd) != k) @(negedge clk);
  endtask

  task automatic finish_turn();
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset sel", 32'(sel_simd), 0);
    chk("R7 reset grant", grant, 0);
    chk("R7 reset count", 32'(issue_cnt), 0);
  endtask

  task automatic t_rotate();
    int prev;
    @(negedge clk);
    prev = int'(sel_simd);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1 rotate idle", 32'(sel_simd), 32'((prev + 1) % 4));
      prev = (prev + 1) % 4;
    end
  endtask

  task automatic t_all_five();
    wait_sel(2);
    for (int c = 0; c < 5; c++) set_slot(2, c, c, 1, 1);
    set_slot(1, 0, 0, 1, 1);
    #1;
    chk("R8 five issue", grant, 32'h001F_0000);
    chk("R7 count five", 32'(issue_cnt), 5);
    chk("R2 other simd", grant & 32'h0000_FF00, 0);
    finish_turn();
  endtask

  task automatic t_conflict();
    wait_sel(0);
    set_slot(0, 3, 1, 1, 1); set_slot(0, 6, 1, 1, 1);
    #1;
    chk("R4 one vmem", grant, 32'h0000_0008);
    chk("R7 count one", 32'(issue_cnt), 1);
    finish_turn();
    wait_sel(0);
    set_slot(0, 3, 1, 1, 1); set_slot(0, 6, 1, 1, 1);
    #1;
    chk("R6 pointer moved", grant, 32'h0000_0040);
    finish_turn();
    wait_sel(0);
    set_slot(0, 3, 1, 1, 1); set_slot(0, 6, 1, 1, 1);
    #1;
    chk("R6 pointer wraps", grant, 32'h0000_0008);
    finish_turn();
  endtask

  task automatic t_block();
    wait_sel(3);
    set_slot(3, 0, 0, 1, 0);
    set_slot(3, 1, 2, 1, 1);
    set_slot(3, 2, 5, 1, 1);
    set_slot(3, 4, 3, 0, 1);
    set_slot(3, 5, 0, 1, 1);
    busy[2] = 1'b1;
    #1;
    chk("R3 blocked slots", grant, 32'h2000_0000);
    chk("R5 count blocked", 32'(issue_cnt), 1);
    finish_turn();
    wait_sel(3);
    set_slot(3, 1, 2, 1, 1);
    #1;
    chk("R5 busy released", grant, 32'h0200_0000);
    finish_turn();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    tests++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rotate();
    t_all_five();
    t_conflict();
    t_block();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule